// File: doc/BRIEF.md
# Configuration Clock Source Switch

This block chooses which clock drives a configuration engine: the on-chip oscillator or an externally supplied user clock. Two decoded instruction strobes from a JTAG instruction decoder steer it. The "use user clock" strobe sets a sticky selection. The "use oscillator" strobe starts a revert back to the internal source. The selection is sticky by design. Reconfiguration requests and all other instructions leave it unchanged. Only the revert strobe or power-on reset clears it.

A revert is a two-domain handshake. The oscillator-domain state machine raises a revert request, and that request is synchronised into the user-clock domain. There a counter has to see ten user-clock rising edges. Its done flag then crosses back through a two-flop synchroniser, and only after that does the selection drop to the oscillator. If the user clock stops, the revert never finishes: the user clock stays selected and reconfiguration stays blocked. In the user-clock domain, a divide-by-two enable marks the configuration data clock while the user clock is selected.

The state machine has five states:

- `ST_OSC`: the oscillator is selected.
- `ST_USR`: the user clock is selected.
- `ST_REV_WAIT`: a revert request is outstanding.
- `ST_REV_DONE`: the revert has just completed; this state lasts one cycle.
- `ST_REV_DRAIN`: the machine waits for the done flag to clear.

Its transitions are:

- enable: `ST_OSC`→`ST_USR` on the enable strobe while the oscillator is running.
- disable: `ST_USR`→`ST_REV_WAIT` on the revert strobe.
- counted: `ST_REV_WAIT`→`ST_REV_DONE` when the synchronised done flag is seen.
- ack: `ST_REV_DONE`→`ST_REV_DRAIN`, unconditionally.
- drained: `ST_REV_DRAIN`→`ST_OSC` once the done flag is low again.
- power-on reset: from any state back to `ST_OSC`.

Top module: `cfg_clk_source_switch`

## Requirements
- R1: After power-on reset, `sel_usr` is 0, `revert_done` is 0 and `dclk_en` is 0.
- R2: An `en_usr_stb` pulse in `ST_OSC` with `osc_on`=1 sets `sel_usr` to 1 at the next `osc_clk` rising edge.
- R3: An `en_usr_stb` pulse while `osc_on`=0 is ignored, and `sel_usr` stays 0.
- R4: Once `sel_usr` is 1, further enable strobes and any activity on `reconfig_req` leave it at 1.
- R5: A `dis_usr_stb` pulse while `sel_usr` is 0 is ignored: no `revert_done` pulse follows and `sel_usr` stays 0.
- R6: After a `dis_usr_stb` pulse in `ST_USR`, `sel_usr` stays 1 until at least 10 `usr_clk` rising edges have occurred. It then falls to 0 together with a `revert_done` pulse that lasts one `osc_clk` cycle.
- R7: While a revert is pending, `reconfig_go` is 0 whatever the value of `reconfig_req`. If `usr_clk` stops, the revert stays pending and `sel_usr` stays 1.
- R8: Asserting `por_n` low clears `sel_usr` at once, even in the middle of a revert, and no `revert_done` pulse follows after release.
- R9: While the user clock is selected, `dclk_en` alternates between 1 and 0 on successive `usr_clk` cycles (divide by two); otherwise it is 0.
- R10: When no revert is pending, `reconfig_go` equals `reconfig_req` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Internal oscillator clock |
| usr_clk | input | 1 | External user clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| osc_on | input | 1 | Oscillator-enabled condition |
| en_usr_stb | input | 1 | Decoded "use user clock" instruction strobe (osc_clk domain) |
| dis_usr_stb | input | 1 | Decoded "use oscillator" instruction strobe (osc_clk domain) |
| reconfig_req | input | 1 | Reconfiguration request |
| sel_usr | output | 1 | 1 = user clock selected, 0 = oscillator selected |
| revert_done | output | 1 | One-cycle pulse when a revert completes |
| reconfig_go | output | 1 | Reconfiguration may proceed |
| dclk_en | output | 1 | Data-clock enable, user clock divided by two |

## Verification
A selection latch stuck at 1 makes `sel_usr` ignore a completed revert, so the port shows it within a few cycles of the expected `revert_done`. A latch stuck at 0 makes `sel_usr` miss the enable one cycle after the strobe. A counter that finishes early shows up as a `sel_usr` fall that comes fewer than ten user-clock edges after the revert strobe. A broken gate shows `reconfig_go` rising during a stalled revert within a single cycle. A divider fault appears as two equal successive `dclk_en` samples in the user domain.

// File: rtl/cfgclk_pkg.sv
`timescale 1ns/1ps
package cfgclk_pkg;
    localparam int unsigned REVERT_EDGES = 10;
    localparam int unsigned SYNC_STAGES  = 2;

    typedef enum logic [2:0] {
        ST_OSC       = 3'd0,
        ST_USR       = 3'd1,
        ST_REV_WAIT  = 3'd2,
        ST_REV_DONE  = 3'd3,
        ST_REV_DRAIN = 3'd4
    } src_state_e;
endpackage

// File: rtl/cfgclk_sync.sv
`timescale 1ns/1ps
// Multi-flop level synchroniser, cleared by power-on reset.
module cfgclk_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cfgclk_revert_cnt.sv
`timescale 1ns/1ps
// User-clock-domain edge counter for the revert handshake.
module cfgclk_revert_cnt #(
    parameter int unsigned EDGES = 10
) (
    input  logic usr_clk,
    input  logic por_n,
    input  logic req_s,
    output logic done
);
    localparam int unsigned CW = $clog2(EDGES + 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    always_ff @(posedge usr_clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!req_s) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(EDGES - 1)) done_q <= 1'b1;
        end
    end

    assign done = done_q;

    assert_cnt_bound_R6: assert property (@(posedge usr_clk) disable iff (!por_n)
        cnt_q <= CW'(EDGES));

    assert_done_not_early_R6: assert property (@(posedge usr_clk) disable iff (!por_n)
        $rose(done_q) |-> (cnt_q == CW'(EDGES)));
endmodule

// File: rtl/cfgclk_dclk_div.sv
`timescale 1ns/1ps
// Divide-by-two data-clock enable, running only while the user clock is selected.
module cfgclk_dclk_div (
    input  logic usr_clk,
    input  logic por_n,
    input  logic sel_s,
    output logic dclk_en
);
    logic tog_q;

    always_ff @(posedge usr_clk or negedge por_n) begin
        if (!por_n)     tog_q <= 1'b0;
        else if (sel_s) tog_q <= ~tog_q;
        else            tog_q <= 1'b0;
    end

    assign dclk_en = tog_q;

    assert_dclk_alternates_R9: assert property (@(posedge usr_clk) disable iff (!por_n)
        (sel_s && $past(sel_s)) |-> (dclk_en != $past(dclk_en)));

    assert_dclk_idle_R9: assert property (@(posedge usr_clk) disable iff (!por_n)
        (!$past(sel_s)) |-> !dclk_en);
endmodule

// File: rtl/cfgclk_src_fsm.sv
`timescale 1ns/1ps
// Oscillator-domain selection state machine.
module cfgclk_src_fsm
    import cfgclk_pkg::*;
(
    input  logic osc_clk,
    input  logic por_n,
    input  logic osc_on,
    input  logic en_stb,
    input  logic dis_stb,
    input  logic done_s,
    input  logic reconfig_req,
    output logic sel_usr,
    output logic revert_req,
    output logic revert_done,
    output logic reconfig_go
);
    src_state_e state_q, state_d;

    always_ff @(posedge osc_clk or negedge por_n) begin
        if (!por_n) state_q <= ST_OSC;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OSC:       if (en_stb && osc_on) state_d = ST_USR;
            ST_USR:       if (dis_stb)          state_d = ST_REV_WAIT;
            ST_REV_WAIT:  if (done_s)           state_d = ST_REV_DONE;
            ST_REV_DONE:                        state_d = ST_REV_DRAIN;
            ST_REV_DRAIN: if (!done_s)          state_d = ST_OSC;
            default:                            state_d = ST_OSC;
        endcase
    end

    always_comb begin
        sel_usr     = 1'b0;
        revert_req  = 1'b0;
        revert_done = 1'b0;
        reconfig_go = reconfig_req;
        unique case (state_q)
            ST_OSC: ;
            ST_USR: sel_usr = 1'b1;
            ST_REV_WAIT: begin
                sel_usr     = 1'b1;
                revert_req  = 1'b1;
                reconfig_go = 1'b0;
            end
            ST_REV_DONE:  revert_done = 1'b1;
            ST_REV_DRAIN: ;
            default: ;
        endcase
    end

    assert_enable_needs_osc_R3: assert property (@(posedge osc_clk) disable iff (!por_n)
        $rose(sel_usr) |-> ($past(en_stb) && $past(osc_on)));

    assert_latch_holds_R4: assert property (@(posedge osc_clk) disable iff (!por_n)
        $fell(sel_usr) |-> $past(done_s));

    assert_no_idle_revert_R5: assert property (@(posedge osc_clk) disable iff (!por_n)
        $rose(revert_req) |-> $past(sel_usr));

    assert_done_single_R6: assert property (@(posedge osc_clk) disable iff (!por_n)
        revert_done |=> !revert_done);

    assert_gate_blocked_R7: assert property (@(posedge osc_clk) disable iff (!por_n)
        revert_req |-> !reconfig_go);
endmodule

// File: rtl/cfg_clk_source_switch.sv
`timescale 1ns/1ps
// Top: configuration clock source switch.
module cfg_clk_source_switch
    import cfgclk_pkg::*;
#(
    parameter int unsigned EDGES  = REVERT_EDGES,
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic osc_clk,
    input  logic usr_clk,
    input  logic por_n,
    input  logic osc_on,
    input  logic en_usr_stb,
    input  logic dis_usr_stb,
    input  logic reconfig_req,
    output logic sel_usr,
    output logic revert_done,
    output logic reconfig_go,
    output logic dclk_en
);
    logic revert_req;
    logic req_usr_s;
    logic cnt_done;
    logic done_osc_s;
    logic sel_usr_s;

    cfgclk_src_fsm u_fsm (
        .osc_clk      (osc_clk),
        .por_n        (por_n),
        .osc_on       (osc_on),
        .en_stb       (en_usr_stb),
        .dis_stb      (dis_usr_stb),
        .done_s       (done_osc_s),
        .reconfig_req (reconfig_req),
        .sel_usr      (sel_usr),
        .revert_req   (revert_req),
        .revert_done  (revert_done),
        .reconfig_go  (reconfig_go)
    );

    cfgclk_sync #(.STAGES(STAGES)) u_req_sync (
        .clk (usr_clk), .rst_n (por_n), .d (revert_req), .q (req_usr_s)
    );

    cfgclk_revert_cnt #(.EDGES(EDGES)) u_cnt (
        .usr_clk (usr_clk), .por_n (por_n), .req_s (req_usr_s), .done (cnt_done)
    );

    cfgclk_sync #(.STAGES(STAGES)) u_done_sync (
        .clk (osc_clk), .rst_n (por_n), .d (cnt_done), .q (done_osc_s)
    );

    cfgclk_sync #(.STAGES(STAGES)) u_sel_sync (
        .clk (usr_clk), .rst_n (por_n), .d (sel_usr), .q (sel_usr_s)
    );

    cfgclk_dclk_div u_div (
        .usr_clk (usr_clk), .por_n (por_n), .sel_s (sel_usr_s), .dclk_en (dclk_en)
    );

    assert_por_clears_R8: assert property (@(posedge osc_clk) disable iff (!por_n)
        $rose(por_n) |-> !sel_usr);
endmodule

// File: tb/cfg_clk_source_switch_tb.sv
`timescale 1ns/1ps
module cfg_clk_source_switch_tb_top;
    logic osc_clk = 1'b0;
    logic usr_clk = 1'b0;
    logic usr_run = 1'b1;
    logic por_n = 1'b0;
    logic osc_on = 1'b1;
    logic en_usr_stb = 1'b0;
    logic dis_usr_stb = 1'b0;
    logic reconfig_req = 1'b0;
    logic sel_usr, revert_done, reconfig_go, dclk_en;

    int n_chk = 0;
    int n_fail = 0;
    int usr_edges = 0;

    always #2.5 osc_clk = ~osc_clk;
    always begin
        #6.25;
        if (usr_run) usr_clk = ~usr_clk;
    end
    always @(posedge usr_clk) usr_edges++;

    cfg_clk_source_switch dut_i (
        .osc_clk(osc_clk), .usr_clk(usr_clk), .por_n(por_n), .osc_on(osc_on),
        .en_usr_stb(en_usr_stb), .dis_usr_stb(dis_usr_stb), .reconfig_req(reconfig_req),
        .sel_usr(sel_usr), .revert_done(revert_done), .reconfig_go(reconfig_go),
        .dclk_en(dclk_en)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_en();
        @(negedge osc_clk) en_usr_stb = 1'b1;
        @(negedge osc_clk) en_usr_stb = 1'b0;
    endtask

    task automatic pulse_dis();
        @(negedge osc_clk) dis_usr_stb = 1'b1;
        @(negedge osc_clk) dis_usr_stb = 1'b0;
    endtask

    // Waits for a revert_done pulse; reports whether sel_usr dropped early.
    task automatic wait_done(output bit seen, output bit early_drop);
        seen = 1'b0;
        early_drop = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge osc_clk);
            if (revert_done) begin
                seen = 1'b1;
                break;
            end
            if (!sel_usr) early_drop = 1'b1;
        end
    endtask

    task automatic t_reset();
        por_n = 1'b0;
        repeat (3) @(negedge osc_clk);
        por_n = 1'b1;
        repeat (2) @(negedge osc_clk);
        check("R1 sel_usr after reset", sel_usr, 0);
        check("R1 revert_done after reset", revert_done, 0);
        check("R1 dclk_en after reset", dclk_en, 0);
        reconfig_req = 1'b1;
        #1;
        check("R10 reconfig_go passes request", reconfig_go, 1);
        reconfig_req = 1'b0;
        #1;
        check("R10 reconfig_go follows release", reconfig_go, 0);
    endtask

    task automatic t_enable_no_osc();
        osc_on = 1'b0;
        pulse_en();
        repeat (3) @(negedge osc_clk);
        check("R3 enable ignored without oscillator", sel_usr, 0);
        osc_on = 1'b1;
    endtask

    task automatic t_enable();
        pulse_en();
        check("R2 sel_usr after enable", sel_usr, 1);
    endtask

    task automatic t_hold();
        pulse_en();
        @(negedge osc_clk) reconfig_req = 1'b1;
        #1;
        check("R10 reconfig_go while user clock selected", reconfig_go, 1);
        @(negedge osc_clk) reconfig_req = 1'b0;
        repeat (20) @(negedge osc_clk);
        check("R4 latch holds after strobes and reconfig", sel_usr, 1);
    endtask

    task automatic t_dclk();
        logic prev;
        int bad;
        bad = 0;
        repeat (6) @(negedge usr_clk);
        prev = dclk_en;
        for (int i = 0; i < 6; i++) begin
            @(negedge usr_clk);
            if (dclk_en == prev) bad++;
            prev = dclk_en;
        end
        check("R9 dclk_en alternation faults", bad, 0);
    endtask

    task automatic t_revert();
        int start;
        bit seen, early;
        start = usr_edges;
        pulse_dis();
        wait_done(seen, early);
        check("R6 revert_done seen", int'(seen), 1);
        check("R6 sel_usr held until done", int'(early), 0);
        check("R6 enough user edges", int'((usr_edges - start) >= 10), 1);
        check("R6 sel_usr cleared at done", sel_usr, 0);
        @(negedge osc_clk);
        check("R6 revert_done one cycle", revert_done, 0);
        repeat (40) @(negedge osc_clk);
        check("R9 dclk_en idle on oscillator", dclk_en, 0);
    endtask

    task automatic t_dis_idle();
        int pulses;
        pulses = 0;
        pulse_dis();
        for (int i = 0; i < 150; i++) begin
            @(negedge osc_clk);
            if (revert_done) pulses++;
        end
        check("R5 no revert_done for idle disable", pulses, 0);
        check("R5 sel_usr stays clear", sel_usr, 0);
    endtask

    task automatic t_stall();
        bit seen, early;
        pulse_en();
        check("R2 re-enable before stall", sel_usr, 1);
        usr_run = 1'b0;
        pulse_dis();
        repeat (200) @(negedge osc_clk);
        check("R7 sel_usr held while user clock stopped", sel_usr, 1);
        reconfig_req = 1'b1;
        #1;
        check("R7 reconfig blocked while pending", reconfig_go, 0);
        @(negedge osc_clk) reconfig_req = 1'b0;
        usr_run = 1'b1;
        wait_done(seen, early);
        check("R7 revert completes after clock resumes", int'(seen), 1);
        repeat (40) @(negedge osc_clk);
    endtask

    task automatic t_por_mid();
        int pulses;
        pulses = 0;
        pulse_en();
        usr_run = 1'b0;
        pulse_dis();
        repeat (20) @(negedge osc_clk);
        por_n = 1'b0;
        #1;
        check("R8 sel_usr cleared by reset", sel_usr, 0);
        usr_run = 1'b1;
        repeat (3) @(negedge osc_clk);
        por_n = 1'b1;
        for (int i = 0; i < 150; i++) begin
            @(negedge osc_clk);
            if (revert_done) pulses++;
        end
        check("R8 no revert_done after reset", pulses, 0);
        check("R8 sel_usr still clear", sel_usr, 0);
        check("R1 dclk_en clear after reset", dclk_en, 0);
    endtask

    initial begin
        t_reset();
        t_enable_no_osc();
        t_enable();
        t_hold();
        t_dclk();
        t_revert();
        t_dis_idle();
        t_stall();
        t_por_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge osc_clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R6 actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule